// File: doc/BRIEF.md
# Packet Memory Tier Power Sequencer

This block decides which off-chip packet-memory tiers are powered. The memory behind a line-card queue is modelled as a fixed on-chip region, one SRAM tier (the SRAM devices and their controller) and a configurable number of DRAM rows behind one shared DRAM controller. A sizing unit upstream gives the capacity it wants active. The sequencer compares that request with the capacity of the tiers already committed. It powers up or releases one tier at a time, always at the edge of the fill order.

Each tier carries a cycle counter. The counter first models the time a tier needs before it can hold data. It then enforces a minimum on-time, so that bursty requests do not make a tier toggle. Downstream logic sees a usable-capacity value, which counts only tiers that have finished waking. It also sees per-tier enable and ready flags and the two controller enables. All latencies are given in microseconds together with the clock frequency in MHz, and they are turned into cycle counts when the design elaborates.

Top module: `memtier_power_seq`

## Requirements
- R1: After reset every tier is disabled, both controller enables are low and `usable_cap` equals `ONCHIP_CAP`.
- R2: Level k means the on-chip region plus the lowest k tiers, where tier 0 is the SRAM and tier j≥1 is DRAM row j-1. Its capacity is ONCHIP_CAP + (k≥1 ? SRAM_CAP : 0) + (k≥2 ? (k-1)·ROW_CAP : 0). While `target_cap` exceeds the capacity of the committed level, and not all tiers are committed, one more tier is enabled.
- R3: Tiers are enabled in ascending index order and only one tier wakes at a time. The enable of tier i+1 rises exactly one cycle after tier i becomes ready, and the enable of tier 0 rises on the first clock edge that samples a larger target.
- R4: The ready flag of the SRAM tier rises exactly SRAM_WAKE_US·CLK_MHZ cycles after its enable rises. For a DRAM row the delay is DRAM_WAKE_US·CLK_MHZ cycles.
- R5: A tier that is enabled but not yet ready adds nothing to `usable_cap`. At all times `usable_cap` is ONCHIP_CAP plus SRAM_CAP if tier 0 is ready, plus ROW_CAP for each ready DRAM row.
- R6: While `target_cap` is at or below the capacity of the committed level minus its highest tier, that highest tier is released. Tiers are released in descending index order, at most one per cycle.
- R7: A ready tier stays ready for at least MIN_ON_US·CLK_MHZ cycles. A release that is already due during that window waits, and then happens exactly when the window ends, with the fall coming MIN_ON_US·CLK_MHZ cycles after the ready flag rose.
- R8: `dram_ctl_on` is high exactly while any DRAM row is enabled. It rises in the same cycle as the enable of row 0 (tier 1) and falls in the same cycle as that enable. `sram_ctl_on` follows the enable of tier 0.
- R9: A target that falls between two level capacities settles at the smallest level whose capacity reaches it. No tier toggles while the target is held.
- R10: At most one tier enable changes in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| target_cap | input | CAP_W | Requested active capacity from the sizing unit |
| tier_en | output | NR+1 | Power enable per tier (bit 0 SRAM, bit j DRAM row j-1); low means asleep |
| tier_ready | output | NR+1 | Tier has finished waking and may hold data |
| sram_ctl_on | output | 1 | SRAM controller power enable |
| dram_ctl_on | output | 1 | DRAM controller power enable |
| usable_cap | output | CAP_W | Capacity of on-chip region plus ready tiers |

## Verification
A target change is sampled on the next rising edge, so the first enable rise is due one cycle after the target is driven. A ready flag follows its enable by exactly the tier's wake count. A release lands exactly the minimum on-time after the ready rise, or one cycle after the release of the tier above, whichever is later. The bench drives inputs on falling edges and stamps every enable and ready transition with the edge counter at the next falling edge. It then compares these stamps with the cycle numbers that the requirements predict, worked out from the wake and hold counts. It does this for every target level, exact and in between, so usable capacity, release order and controller enables are all checked against the same timeline.

// File: rtl/mt_pkg.sv
package mt_pkg;

   typedef enum logic [1:0] {
      TS_SLEEP = 2'd0,
      TS_WAKE  = 2'd1,
      TS_ON    = 2'd2
   } tier_state_t;

   function automatic int max_int(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mt_tier_cell.sv
module mt_tier_cell
   import mt_pkg::*;
#(
   parameter int CNT_W    = 8,
   parameter int WAKE_CYC = 4,
   parameter int HOLD_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wake_go,
   input  logic sleep_go,
   output logic en_o,
   output logic ready_o,
   output logic hold_done_o
);

   tier_state_t      st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st  <= TS_SLEEP;
         cnt <= '0;
      end else begin
         unique case (st)
            TS_SLEEP: begin
               if (wake_go) begin
                  st  <= TS_WAKE;
                  cnt <= CNT_W'(WAKE_CYC - 1);
               end
            end
            TS_WAKE: begin
               if (cnt == '0) begin
                  st  <= TS_ON;
                  cnt <= CNT_W'(HOLD_CYC - 1);
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            TS_ON: begin
               if (sleep_go && cnt == '0) st <= TS_SLEEP;
               else if (cnt != '0)        cnt <= cnt - 1'b1;
            end
            default: st <= TS_SLEEP;
         endcase
      end
   end

   assign en_o        = (st != TS_SLEEP);
   assign ready_o     = (st == TS_ON);
   assign hold_done_o = (st == TS_ON) && (cnt == '0);

   // checker counters: cycles spent waking and cycles spent usable
   logic [CNT_W-1:0] wake_age, on_age;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_age <= '0;
         on_age   <= '0;
      end else begin
         wake_age <= (st == TS_WAKE) ? wake_age + 1'b1 : '0;
         if (st != TS_ON)                      on_age <= '0;
         else if (on_age != CNT_W'(HOLD_CYC))  on_age <= on_age + 1'b1;
      end
   end

   p_wake_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready_o) |-> wake_age == CNT_W'(WAKE_CYC));
   p_waking_not_usable_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(en_o) |-> !ready_o);
   p_min_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ready_o) |-> on_age >= CNT_W'(HOLD_CYC));
   p_sleep_from_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(en_o) |-> $past(ready_o && hold_done_o));

endmodule

// File: rtl/mt_level_ctrl.sv
module mt_level_ctrl #(
   parameter int NT         = 3,
   parameter int LVL_W      = 2,
   parameter int CAP_W      = 16,
   parameter int ONCHIP_CAP = 16,
   parameter int SRAM_CAP   = 64,
   parameter int ROW_CAP    = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CAP_W-1:0] target_cap,
   input  logic [NT-1:0]    tier_en,
   input  logic [NT-1:0]    tier_ready,
   input  logic [NT-1:0]    tier_hold_done,
   output logic [NT-1:0]    wake_go,
   output logic [NT-1:0]    sleep_go
);

   function automatic logic [CAP_W-1:0] level_cap(input logic [LVL_W-1:0] k);
      logic [CAP_W-1:0] c;
      c = CAP_W'(ONCHIP_CAP);
      if (k >= LVL_W'(1)) c = c + CAP_W'(SRAM_CAP);
      if (k >= LVL_W'(2)) c = c + CAP_W'(k - LVL_W'(1)) * CAP_W'(ROW_CAP);
      return c;
   endfunction

   logic [LVL_W-1:0] lvl;
   logic             busy, top_free, grow, shrink;
   logic [CAP_W-1:0] cap_now, cap_less;

   assign busy     = |(tier_en & ~tier_ready);
   assign cap_now  = level_cap(lvl);
   assign cap_less = (lvl != '0) ? level_cap(lvl - LVL_W'(1)) : cap_now;

   always_comb begin
      top_free = 1'b0;
      for (int i = 0; i < NT; i++) begin
         if (lvl == LVL_W'(i + 1)) top_free = tier_ready[i] && tier_hold_done[i];
      end
   end

   assign grow   = !busy && (lvl != LVL_W'(NT)) && (target_cap > cap_now);
   assign shrink = (lvl != '0) && top_free && (target_cap <= cap_less);

   always_comb begin
      for (int i = 0; i < NT; i++) begin
         wake_go[i]  = grow   && (lvl == LVL_W'(i));
         sleep_go[i] = shrink && (lvl == LVL_W'(i + 1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lvl <= '0;
      else if (grow)   lvl <= lvl + LVL_W'(1);
      else if (shrink) lvl <= lvl - LVL_W'(1);
   end

   p_grow_shrink_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wake_go | sleep_go));

endmodule

// File: rtl/mt_cap_sum.sv
module mt_cap_sum #(
   parameter int NT         = 3,
   parameter int CAP_W      = 16,
   parameter int ONCHIP_CAP = 16,
   parameter int SRAM_CAP   = 64,
   parameter int ROW_CAP    = 256
) (
   input  logic [NT-1:0]    tier_ready,
   output logic [CAP_W-1:0] usable_cap
);

   always_comb begin
      usable_cap = CAP_W'(ONCHIP_CAP);
      for (int i = 0; i < NT; i++) begin
         if (tier_ready[i]) usable_cap = usable_cap + ((i == 0) ? CAP_W'(SRAM_CAP) : CAP_W'(ROW_CAP));
      end
   end

endmodule

// File: rtl/memtier_power_seq.sv
module memtier_power_seq
   import mt_pkg::*;
#(
   parameter int NR           = 4,
   parameter int CAP_W        = 32,
   parameter int ONCHIP_CAP   = 256,
   parameter int SRAM_CAP     = 4096,
   parameter int ROW_CAP      = 262144,
   parameter int CLK_MHZ      = 200,
   parameter int SRAM_WAKE_US = 50,
   parameter int DRAM_WAKE_US = 500,
   parameter int MIN_ON_US    = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CAP_W-1:0] target_cap,
   output logic [NR:0]      tier_en,
   output logic [NR:0]      tier_ready,
   output logic             sram_ctl_on,
   output logic             dram_ctl_on,
   output logic [CAP_W-1:0] usable_cap
);

   localparam int NT            = NR + 1;
   localparam int LVL_W         = $clog2(NT + 1);
   localparam int SRAM_WAKE_CYC = SRAM_WAKE_US * CLK_MHZ;
   localparam int DRAM_WAKE_CYC = DRAM_WAKE_US * CLK_MHZ;
   localparam int MIN_ON_CYC    = MIN_ON_US * CLK_MHZ;
   localparam int MAX_CYC       = max_int(max_int(SRAM_WAKE_CYC, DRAM_WAKE_CYC), MIN_ON_CYC);
   localparam int CNT_W         = $clog2(MAX_CYC + 1);
   localparam longint FULL_CAP  = longint'(ONCHIP_CAP) + longint'(SRAM_CAP) + longint'(NR) * longint'(ROW_CAP);

   if (NR < 1) begin : g_bad_rows
      $error("memtier_power_seq: NR must be at least 1");
   end
   if (SRAM_WAKE_CYC < 1 || DRAM_WAKE_CYC < 1 || MIN_ON_CYC < 1) begin : g_bad_time
      $error("memtier_power_seq: every latency must be at least one cycle");
   end
   if (CAP_W < 2 || CAP_W > 62 || FULL_CAP >= (longint'(1) << CAP_W)) begin : g_bad_cap
      $error("memtier_power_seq: total capacity does not fit CAP_W");
   end

   logic [NT-1:0] wake_go, sleep_go, hold_done;

   mt_level_ctrl #(
      .NT(NT), .LVL_W(LVL_W), .CAP_W(CAP_W),
      .ONCHIP_CAP(ONCHIP_CAP), .SRAM_CAP(SRAM_CAP), .ROW_CAP(ROW_CAP)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .target_cap(target_cap),
      .tier_en(tier_en), .tier_ready(tier_ready), .tier_hold_done(hold_done),
      .wake_go(wake_go), .sleep_go(sleep_go)
   );

   for (genvar gi = 0; gi < NT; gi++) begin : g_tier
      localparam int WAKE = (gi == 0) ? SRAM_WAKE_CYC : DRAM_WAKE_CYC;
      mt_tier_cell #(
         .CNT_W(CNT_W), .WAKE_CYC(WAKE), .HOLD_CYC(MIN_ON_CYC)
      ) u_cell (
         .clk(clk), .rst_n(rst_n),
         .wake_go(wake_go[gi]), .sleep_go(sleep_go[gi]),
         .en_o(tier_en[gi]), .ready_o(tier_ready[gi]), .hold_done_o(hold_done[gi])
      );
      if (gi > 0) begin : g_order
         p_fill_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
            tier_en[gi] |-> tier_ready[gi-1]);
      end
   end

   mt_cap_sum #(
      .NT(NT), .CAP_W(CAP_W),
      .ONCHIP_CAP(ONCHIP_CAP), .SRAM_CAP(SRAM_CAP), .ROW_CAP(ROW_CAP)
   ) u_sum (
      .tier_ready(tier_ready), .usable_cap(usable_cap)
   );

   assign sram_ctl_on = tier_en[0];
   assign dram_ctl_on = |tier_en[NR:1];

   p_one_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tier_en ^ $past(tier_en)) <= 1);
   p_dram_ctl_with_row0_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dram_ctl_on) |-> $rose(tier_en[1]));
   p_cap_tracks_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(usable_cap) |-> !$stable(tier_ready));

endmodule

// File: tb/test_memtier_power_seq.sv
`timescale 1ns/1ps
module test_memtier_power_seq;

   localparam int NR = 3, NT = 4, CAP_W = 16;
   localparam int ONC = 16, SRC = 64, ROWC = 256;
   localparam int MHZ = 1, SW = 3, DW = 5, MO = 9;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [CAP_W-1:0] target_cap = '0;
   logic [NT-1:0]    tier_en, tier_ready;
   logic             sram_ctl_on, dram_ctl_on;
   logic [CAP_W-1:0] usable_cap;

   memtier_power_seq #(
      .NR(NR), .CAP_W(CAP_W), .ONCHIP_CAP(ONC), .SRAM_CAP(SRC), .ROW_CAP(ROWC),
      .CLK_MHZ(MHZ), .SRAM_WAKE_US(SW), .DRAM_WAKE_US(DW), .MIN_ON_US(MO)
   ) i_memtier_power_seq (
      .clk(clk), .rst_n(rst_n), .target_cap(target_cap),
      .tier_en(tier_en), .tier_ready(tier_ready),
      .sram_ctl_on(sram_ctl_on), .dram_ctl_on(dram_ctl_on), .usable_cap(usable_cap)
   );

   always #2.5 clk = ~clk;

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0, fails = 0;
   int en_rise[NT], en_fall[NT], rd_rise[NT];
   int dram_rise, dram_fall;
   int bg_r5 = 0, bg_r8 = 0, bg_r10 = 0;
   logic [NT-1:0] p_en = '0, p_rd = '0;
   logic p_dram = 1'b0;

   function automatic int cap_of(input int k);
      return ONC + ((k >= 1) ? SRC : 0) + ((k >= 2) ? (k - 1) * ROWC : 0);
   endfunction
   function automatic int wake_of(input int i);
      return ((i == 0) ? SW : DW) * MHZ;
   endfunction
   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // transition stamps and continuous properties, sampled on falling edges
   always @(negedge clk) begin
      if (!rst_n) begin
         p_en = '0; p_rd = '0; p_dram = 1'b0;
      end else begin
         int exp_cap;
         exp_cap = ONC;
         for (int i = 0; i < NT; i++) begin
            if (tier_en[i] && !p_en[i])    en_rise[i] = cyc;
            if (!tier_en[i] && p_en[i])    en_fall[i] = cyc;
            if (tier_ready[i] && !p_rd[i]) rd_rise[i] = cyc;
            if (tier_ready[i]) exp_cap += (i == 0) ? SRC : ROWC;
         end
         if (dram_ctl_on && !p_dram) dram_rise = cyc;
         if (!dram_ctl_on && p_dram) dram_fall = cyc;
         if (int'(usable_cap) != exp_cap) bg_r5++;
         if (dram_ctl_on != (|tier_en[NT-1:1]) || sram_ctl_on != tier_en[0]) bg_r8++;
         if ($countones(tier_en ^ p_en) > 1) bg_r10++;
         p_en = tier_en; p_rd = tier_ready; p_dram = dram_ctl_on;
      end
   end

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      target_cap = '0;
      for (int i = 0; i < NT; i++) begin
         en_rise[i] = -1; en_fall[i] = -1; rd_rise[i] = -1;
      end
      dram_rise = -1; dram_fall = -1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic set_target(input int v, output int n0);
      n0 = cyc;
      target_cap = CAP_W'(v);
   endtask

   task automatic run_summary();
      chk(bg_r5 == 0, "R5 usable capacity equals on-chip plus ready tiers", bg_r5, 0);
      chk(bg_r8 == 0, "R8 controller enables follow tier enables", bg_r8, 0);
      chk(bg_r10 == 0, "R10 one enable change per cycle", bg_r10, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      int n0, n1, tgt;

      // grow sweep: exact levels (mid=0) and in-between targets (mid=1)
      for (int mid = 0; mid < 2; mid++) begin
         for (int k = 0; k <= NT; k++) begin
            do_reset();
            if (k == 0 && mid == 0) begin
               chk(tier_en == '0 && tier_ready == '0, "R1 tiers asleep", int'(tier_en), 0);
               chk(!sram_ctl_on && !dram_ctl_on, "R1 controllers off", int'({sram_ctl_on, dram_ctl_on}), 0);
               chk(int'(usable_cap) == ONC, "R1 on-chip capacity only", int'(usable_cap), ONC);
            end
            if (mid == 1 && k == 0) continue;
            tgt = (mid == 1) ? cap_of(k - 1) + 1 : cap_of(k);
            set_target(tgt, n0);
            @(negedge clk);
            if (k >= 1)
               chk(tier_en[0] && int'(usable_cap) == ONC, "R5 waking SRAM not counted",
                   int'(usable_cap), ONC);
            repeat (60) @(negedge clk);
            chk(int'(usable_cap) == cap_of(k), (mid == 1) ? "R9 settles at covering level" : "R2 level capacity",
                int'(usable_cap), cap_of(k));
            chk(int'(tier_en) == (1 << k) - 1, "R2 committed tier count", int'(tier_en), (1 << k) - 1);
            if (mid == 1) begin
               int nfall;
               nfall = 0;
               for (int i = 0; i < NT; i++) if (en_fall[i] != -1) nfall++;
               chk(nfall == 0, "R9 no toggling on steady target", nfall, 0);
            end else begin
               for (int i = 0; i < k; i++) begin
                  int exp_en;
                  exp_en = (i == 0) ? n0 + 1 : rd_rise[i-1] + 1;
                  chk(en_rise[i] == exp_en, "R3 ascending wake timing", en_rise[i], exp_en);
                  chk(rd_rise[i] - en_rise[i] == wake_of(i), "R4 wake latency",
                      rd_rise[i] - en_rise[i], wake_of(i));
               end
               if (k >= 2)
                  chk(dram_rise == en_rise[1], "R8 DRAM controller with row 0", dram_rise, en_rise[1]);
            end
         end
      end

      // full release: descending order, held minimum on-time
      do_reset();
      set_target(cap_of(NT), n0);
      for (int w = 0; w < 100 && !tier_ready[NT-1]; w++) @(negedge clk);
      set_target(cap_of(0), n1);
      repeat (60) @(negedge clk);
      chk(en_fall[NT-1] == rd_rise[NT-1] + MO * MHZ, "R7 release waits for minimum on-time",
          en_fall[NT-1], rd_rise[NT-1] + MO * MHZ);
      for (int i = NT - 2; i >= 0; i--) begin
         int exp_f;
         exp_f = imax(en_fall[i+1] + 1, rd_rise[i] + MO * MHZ);
         chk(en_fall[i] == exp_f, "R6 descending release", en_fall[i], exp_f);
      end
      chk(dram_fall == en_fall[1], "R8 DRAM controller off with last row", dram_fall, en_fall[1]);
      chk(int'(usable_cap) == ONC && tier_en == '0, "R6 all released", int'(usable_cap), ONC);

      // partial release down to SRAM plus row 0
      do_reset();
      set_target(cap_of(NT), n0);
      for (int w = 0; w < 100 && !tier_ready[NT-1]; w++) @(negedge clk);
      set_target(cap_of(2), n1);
      repeat (60) @(negedge clk);
      chk(tier_en == 4'b0011, "R6 release stops at covering level", int'(tier_en), 3);
      chk(en_fall[2] == imax(en_fall[3] + 1, rd_rise[2] + MO * MHZ), "R6 second release timing",
          en_fall[2], imax(en_fall[3] + 1, rd_rise[2] + MO * MHZ));
      chk(int'(usable_cap) == cap_of(2), "R6 capacity after partial release", int'(usable_cap), cap_of(2));

      // target drops while SRAM is still waking
      do_reset();
      set_target(cap_of(2), n0);
      @(negedge clk);
      set_target(cap_of(0), n1);
      repeat (40) @(negedge clk);
      chk(rd_rise[0] == n0 + 1 + SW * MHZ, "R4 SRAM finishes waking", rd_rise[0], n0 + 1 + SW * MHZ);
      chk(en_fall[0] == rd_rise[0] + MO * MHZ, "R7 held release after wake", en_fall[0], rd_rise[0] + MO * MHZ);
      chk(en_rise[1] == -1, "R3 no further tier woken", en_rise[1], -1);

      run_summary();
   end

endmodule